// File: doc/BRIEF.md
# Supply-Loss Protection and Backup-Power Sequencer

This block sits beside a battery-backed byte-wide memory. It decides when that memory must stop taking accesses, and when it must run from its backup cell. It watches three comparator flags, each saying whether the main supply is above one level. The highest flag is the top of the protection window. The middle flag is the bottom of that window. The lowest flag is the level at which the memory changes over to the battery. The block drives a combined block/write-protect line, a line that forces the memory's data outputs off the bus, and a battery-select line.

Each flag is resynchronised and then debounced: it must hold a new value for a set number of cycles before the sequencer reacts. Protection starts as soon as the supply leaves the safe range. Protection ends only after a programmable recovery interval has run out. That interval starts once the supply is back above the window's bottom. The supply must also be back above the window's top before protection is released. A dip below the window's bottom during recovery cancels the interval, and the next rise starts it again from zero. The sequencer acts on the whole memory at once with a single blocking decision, so a supply loss during a write can only touch the location being written.

Top module: `pwr_guard_ctrl`

## Requirements
- R1: When the upper-level flag goes low while the supply is good, `mem_block` and `out_hiz` go high on rising edge number SYNC_STAGES+STABLE_CYC+1 after the change, counting the first edge that samples the new value as number 1. `batt_sel` stays low.
- R2: While the lower-level flag is low, `mem_block` and `out_hiz` stay high.
- R3: While the switchover flag is low, `batt_sel` is high. If all three flags fall in the same cycle, `batt_sel` and `mem_block` rise on the same edge.
- R4: When the switchover flag returns high, `batt_sel` goes low and `mem_block` stays high.
- R5: After the lower and upper flags both return high, `mem_block` and `out_hiz` fall on rising edge SYNC_STAGES+STABLE_CYC+1+REC_CYC, counted the same way as in R1. Before that edge they stay high.
- R6: If the lower flag drops during recovery, the interval is discarded. After the next rise, release again takes the full count given in R5.
- R7: A flag change that lasts fewer than STABLE_CYC cycles has no effect on any output.
- R8: Protection is not released while the upper flag is low, however long the recovery interval has run.
- R9: During reset and right after it, `mem_block`, `out_hiz` and `batt_sel` are all high.
- R10: `batt_sel` is never high while `mem_block` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sup_above_hi | input | 1 | Supply above the top of the protection window |
| sup_above_lo | input | 1 | Supply above the bottom of the protection window |
| sup_above_sw | input | 1 | Supply above the battery switchover level |
| mem_block | output | 1 | Block accesses and protect the memory from writes |
| out_hiz | output | 1 | Force the memory's data outputs to high impedance |
| batt_sel | output | 1 | Power the memory from the backup cell |

## Verification
Protection and battery switchover can begin in the same cycle. This happens when the supply collapses fast enough that all three comparators fall together. The bench provokes it by dropping all three flags on one clock edge while the memory is in normal operation. It then counts edges until `mem_block` rises and requires `batt_sel` to be high at that same sample. The mirror case is also checked: on the way back up, battery release and protection release must land in different cycles, with the recovery interval between them.

// File: rtl/pg_pkg.sv
package pg_pkg;
   typedef enum logic [1:0] {
      ST_NORMAL = 2'd0,
      ST_DESEL  = 2'd1,
      ST_BATT   = 2'd2,
      ST_RECOV  = 2'd3
   } pg_state_t;

   localparam int unsigned FLAG_HI = 0;
   localparam int unsigned FLAG_LO = 1;
   localparam int unsigned FLAG_SW = 2;
   localparam int unsigned NUM_FLAGS = 3;
endpackage

// File: rtl/pg_flag_filter.sv
module pg_flag_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned STABLE_CYC  = 4,
   parameter bit          RST_VAL     = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_in,
   output logic flag_out
);
   localparam int unsigned CW = (STABLE_CYC < 2) ? 1 : $clog2(STABLE_CYC + 1);
   localparam logic [CW-1:0] CNT_LAST = CW'(STABLE_CYC - 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pg_flag_filter: SYNC_STAGES must be at least 2");
   end
   if (STABLE_CYC < 1) begin : g_bad_stable
      $error("pg_flag_filter: STABLE_CYC must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;
   logic [CW-1:0]          cnt_q;
   logic                   filt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= {SYNC_STAGES{RST_VAL}};
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
   end

   assign synced = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_q <= RST_VAL;
         cnt_q  <= '0;
      end else if (synced == filt_q) begin
         cnt_q  <= '0;
      end else if (cnt_q == CNT_LAST) begin
         filt_q <= synced;
         cnt_q  <= '0;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign flag_out = filt_q;

   // R7: the debounced flag only ever moves to the value the synchronizer held
   a_r7_follow_sync: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_q != $past(filt_q)) |-> (filt_q == $past(synced)))
      else $error("R7: filtered flag took a value the synchronizer did not hold");
endmodule

// File: rtl/pg_recov_timer.sv
module pg_recov_timer #(
   parameter int unsigned REC_CYC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int unsigned TW = $clog2(REC_CYC);
   localparam logic [TW-1:0] T_LAST = TW'(REC_CYC - 1);

   if (REC_CYC < 2) begin : g_bad_rec
      $error("pg_recov_timer: REC_CYC must be at least 2");
   end

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (!run)            cnt_q <= '0;
      else if (cnt_q != T_LAST) cnt_q <= cnt_q + 1'b1;
   end

   assign done = run && (cnt_q == T_LAST);

   // R5: the count saturates at its last value and never wraps
   a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= T_LAST)
      else $error("R5: recovery count ran past its limit");

   // R6: leaving recovery clears the interval
   a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0))
      else $error("R6: recovery count not cleared");
endmodule

// File: rtl/pwr_guard_ctrl.sv
module pwr_guard_ctrl #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned STABLE_CYC  = 16,
   parameter int unsigned REC_CYC     = 2000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sup_above_hi,
   input  logic sup_above_lo,
   input  logic sup_above_sw,
   output logic mem_block,
   output logic out_hiz,
   output logic batt_sel
);
   import pg_pkg::*;

   logic [NUM_FLAGS-1:0] raw_v;
   logic [NUM_FLAGS-1:0] flt_v;
   logic                 f_hi, f_lo, f_sw;
   logic                 rec_done;
   pg_state_t            state_q, state_d;
   logic                 blk_q, hiz_q, batt_q;

   assign raw_v[FLAG_HI] = sup_above_hi;
   assign raw_v[FLAG_LO] = sup_above_lo;
   assign raw_v[FLAG_SW] = sup_above_sw;

   for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
      pg_flag_filter #(
         .SYNC_STAGES (SYNC_STAGES),
         .STABLE_CYC  (STABLE_CYC),
         .RST_VAL     (1'b0)
      ) u_filt (
         .clk      (clk),
         .rst_n    (rst_n),
         .raw_in   (raw_v[g]),
         .flag_out (flt_v[g])
      );
   end

   assign f_hi = flt_v[FLAG_HI];
   assign f_lo = flt_v[FLAG_LO];
   assign f_sw = flt_v[FLAG_SW];

   pg_recov_timer #(.REC_CYC(REC_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state_q == ST_RECOV),
      .done  (rec_done)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_NORMAL: begin
            if (!f_sw)      state_d = ST_BATT;
            else if (!f_hi) state_d = ST_DESEL;
         end
         ST_DESEL: begin
            if (!f_sw)      state_d = ST_BATT;
            else if (f_lo)  state_d = ST_RECOV;
         end
         ST_BATT: begin
            if (f_sw)       state_d = ST_DESEL;
         end
         ST_RECOV: begin
            if (!f_sw)                 state_d = ST_BATT;
            else if (!f_lo)            state_d = ST_DESEL;
            else if (rec_done && f_hi) state_d = ST_NORMAL;
         end
         default:           state_d = ST_DESEL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_DESEL;
         blk_q   <= 1'b1;
         hiz_q   <= 1'b1;
         batt_q  <= 1'b1;
      end else begin
         state_q <= state_d;
         blk_q   <= (state_d != ST_NORMAL);
         hiz_q   <= (state_d != ST_NORMAL);
         batt_q  <= (state_d == ST_BATT);
      end
   end

   assign mem_block = blk_q;
   assign out_hiz   = hiz_q;
   assign batt_sel  = batt_q;

   // R1: a debounced upper flag that is low protects the memory on the next edge
   a_r1_window_block: assert property (@(posedge clk) disable iff (!rst_n)
      !f_hi |=> (mem_block && out_hiz))
      else $error("R1: window entered but memory not blocked");

   // R2: below the lower level the memory stays write protected
   a_r2_low_protect: assert property (@(posedge clk) disable iff (!rst_n)
      !f_lo |=> mem_block)
      else $error("R2: memory unprotected below lower level");

   // R3: below switchover the battery is selected
   a_r3_batt_on: assert property (@(posedge clk) disable iff (!rst_n)
      !f_sw |=> batt_sel)
      else $error("R3: battery not selected below switchover");

   // R5: release only when the recovery timer reports completion
   a_r5_release_timed: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_block) |-> $past(rec_done))
      else $error("R5: protection released before recovery elapsed");

   // R10: battery power never coexists with open access
   a_r10_batt_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      batt_sel |-> mem_block)
      else $error("R10: battery selected while access open");
endmodule

// File: tb/pwr_guard_ctrl_test.sv
module pwr_guard_ctrl_test;
   localparam int unsigned S   = 2;
   localparam int unsigned F   = 4;
   localparam int unsigned REC = 50;
   localparam int unsigned LAT_BLOCK   = S + F + 1;
   localparam int unsigned LAT_RELEASE = S + F + 1 + REC;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic v_hi = 1'b0, v_lo = 1'b0, v_sw = 1'b0;
   logic mem_block, out_hiz, batt_sel;
   int   total = 0;
   int   bad = 0;
   bit   finished = 1'b0;

   always #10 clk = ~clk;

   pwr_guard_ctrl #(.SYNC_STAGES(S), .STABLE_CYC(F), .REC_CYC(REC)) uut (
      .clk(clk), .rst_n(rst_n),
      .sup_above_hi(v_hi), .sup_above_lo(v_lo), .sup_above_sw(v_sw),
      .mem_block(mem_block), .out_hiz(out_hiz), .batt_sel(batt_sel)
   );

   task automatic check(input string tag, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   // counts rising edges until mem_block equals val; sampled at falling edges
   task automatic edges_to_block(input logic val, input int limit, output int n);
      n = 0;
      for (int i = 0; i < limit; i++) begin
         @(posedge clk);
         @(negedge clk);
         n++;
         if (mem_block == val) return;
      end
      n = -1;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      tick(2);
      check("R9 block in reset", mem_block, 1);
      check("R9 hiz in reset", out_hiz, 1);
      check("R9 batt in reset", batt_sel, 1);
      rst_n = 1'b1;
      tick(3);
      check("R9 batt after reset", batt_sel, 1);
      check("R9 block after reset", mem_block, 1);
   endtask

   task automatic t_powerup();
      int n;
      v_sw = 1'b1;
      tick(20);
      check("R4 batt off above switchover", batt_sel, 0);
      check("R4 still protected", mem_block, 1);
      v_lo = 1'b1;
      v_hi = 1'b1;
      edges_to_block(1'b0, LAT_RELEASE + 20, n);
      check("R5 release edge count", n, LAT_RELEASE);
      check("R5 hiz released", out_hiz, 0);
   endtask

   task automatic t_spike();
      int seen = 0;
      v_hi = 1'b0;
      tick(F - 1);
      v_hi = 1'b1;
      for (int i = 0; i < 20; i++) begin
         tick(1);
         if (mem_block || out_hiz || batt_sel) seen++;
      end
      check("R7 short spike ignored", seen, 0);
   endtask

   task automatic t_window();
      int n;
      v_hi = 1'b0;
      edges_to_block(1'b1, 40, n);
      check("R1 block edge count", n, LAT_BLOCK);
      check("R1 hiz in window", out_hiz, 1);
      check("R1 no battery in window", batt_sel, 0);
      tick(REC + 20);
      check("R8 held while upper low", mem_block, 1);
   endtask

   task automatic t_below_lo();
      v_lo = 1'b0;
      tick(20);
      check("R2 protected below lower", mem_block, 1);
      check("R2 hiz below lower", out_hiz, 1);
      check("R2 battery still off", batt_sel, 0);
   endtask

   task automatic t_battery();
      v_sw = 1'b0;
      tick(20);
      check("R3 battery selected", batt_sel, 1);
      check("R3 protected on battery", mem_block, 1);
      v_sw = 1'b1;
      tick(20);
      check("R4 battery released", batt_sel, 0);
      check("R4 protection kept", mem_block, 1);
   endtask

   task automatic t_restart();
      int n;
      v_lo = 1'b1;
      v_hi = 1'b1;
      tick(S + F + 1 + REC / 2);
      check("R6 mid recovery protected", mem_block, 1);
      v_lo = 1'b0;
      tick(10);
      v_lo = 1'b1;
      edges_to_block(1'b0, LAT_RELEASE + 40, n);
      check("R6 full interval after dip", n, LAT_RELEASE);
   endtask

   task automatic t_crash();
      int n;
      v_hi = 1'b0;
      v_lo = 1'b0;
      v_sw = 1'b0;
      edges_to_block(1'b1, 40, n);
      check("R3 crash block edge count", n, LAT_BLOCK);
      check("R3 battery same edge as block", batt_sel, 1);
      check("R10 battery implies blocked", mem_block, 1);
   endtask

   initial begin
      t_reset();
      t_powerup();
      t_spike();
      t_window();
      t_below_lo();
      t_battery();
      t_restart();
      t_crash();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: got 0 expected 1 (run completion)");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule